// File: doc/BRIEF.md
# Serial Frame Receiver with Error Rejection

This block sits behind an external clock-recovery stage. It takes one recovered bit per `in_vld` strobe and rebuilds 16-bit words. Each word on the wire has a start bit at level 1, the data bits with the most significant first, an even parity bit, and a stop bit at level 0. The line rests at 0 between frames. After a stop bit, a 1 starts the next word of the same frame. A second 0 closes the frame.

A word that passes both checks is presented on `word_data` and announced on `word_stb`. It is also written to an external receive FIFO through `fifo_wr`, provided the FIFO is not full. The first parity or stop-bit error poisons the rest of its frame, so every later word of that frame is thrown away. Words already written stay in the FIFO. A sticky error flag records the fault until the host clears it. A one-cycle `frame_done` pulse marks every frame end, whether or not the frame had an error. A loopback input switches the receiver from the line to the local transmit stream.

Top module: `frame_rx`

## Requirements
- R1: After reset, `busy`, `word_stb`, `fifo_wr`, `frame_done` and `err_flag` are all 0.
- R2: A word is a start bit (1), 16 data bits with the MSB first, an even parity bit (data XOR parity = 0) and a stop bit (0). A correct word pulses `fifo_wr` for one cycle, in the cycle after its stop bit is taken, and `word_data` then holds the word.
- R3: A word whose parity bit breaks even parity is not written, and `err_flag` is set.
- R4: A stop bit that reads as 1 is a framing error. The word is not written, and `err_flag` is set.
- R5: Once a word of a frame has an error, every later word of the same frame is dropped. Words written earlier in the frame are not affected.
- R6: A start bit right after a stop bit continues the frame. A 0 right after a stop bit ends the frame and gives a single-cycle `frame_done` pulse, for good and errored frames alike.
- R7: `busy` rises in the cycle after a start bit taken while idle, and stays high until the cycle in which `frame_done` pulses.
- R8: `word_stb` pulses for each correct word of a frame that has not yet seen an error. `word_data` stays stable from the stop bit through the continue period.
- R9: While `fifo_full` is high, `fifo_wr` stays low, but `word_stb` and `frame_done` still pulse.
- R10: While `lb_en` is high, the receiver takes `lb_bit`/`lb_vld` and ignores `in_bit`/`in_vld` entirely.
- R11: `err_flag` stays set until an `err_clr` pulse. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_bit | input | 1 | Recovered line bit |
| in_vld | input | 1 | Line bit valid strobe |
| lb_en | input | 1 | Select loopback source |
| lb_bit | input | 1 | Local transmit bit |
| lb_vld | input | 1 | Local transmit bit valid |
| fifo_full | input | 1 | Receive FIFO is full |
| err_clr | input | 1 | Clear sticky error flag |
| word_data | output | 16 | Received word |
| word_stb | output | 1 | Correct word in a clean frame |
| fifo_wr | output | 1 | FIFO write enable |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | Frame end pulse |
| err_flag | output | 1 | Sticky error flag |

## Verification
The hardest state to reach is a frame that turns bad partway through. A clean word has to be written first, then an error has to occur, and then a correct word in the same frame has to be dropped. The stimulus gets there with multi-word frame vectors that corrupt either the parity bit or the stop bit of a middle word and keep the later words valid. The bench checks the write count word by word. Two further conditions need deliberately conflicting inputs. In one, the FIFO-full input is held while a good frame arrives. In the other, loopback is selected while the line carries an opposite, fully strobed pattern.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_PAR, ST_STOP, ST_CONT
  } rx_state_e;

  localparam logic START_LVL = 1'b1;
  localparam logic STOP_LVL  = 1'b0;

  // even parity: the XOR of all data bits and the parity bit is zero
  function automatic logic parity_ok(input logic data_xor, input logic par_bit);
    return (data_xor ^ par_bit) == 1'b0;
  endfunction

  function automatic logic word_ok(input logic par_good, input logic stop_bit);
    return par_good && (stop_bit == STOP_LVL);
  endfunction
endpackage

// File: rtl/rxf_src_mux.sv
module rxf_src_mux (
  input  logic lb_en,
  input  logic line_bit,
  input  logic line_vld,
  input  logic lb_bit,
  input  logic lb_vld,
  output logic sel_bit,
  output logic sel_vld
);
  always_comb begin
    if (lb_en) begin
      sel_bit = lb_bit;
      sel_vld = lb_vld;
    end else begin
      sel_bit = line_bit;
      sel_vld = line_vld;
    end
  end
endmodule

// File: rtl/rxf_shift.sv
module rxf_shift #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_clr,
  input  logic              shift_en,
  input  logic              par_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data_q,
  output logic              last_bit,
  output logic              par_good
);
  logic [CNT_W-1:0] cnt_q;
  logic             par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
      par_q  <= 1'b0;
    end else begin
      if (cnt_clr)
        cnt_q <= '0;
      else if (shift_en)
        cnt_q <= cnt_q + 1'b1;
      if (shift_en)
        data_q <= {data_q[DATA_W-2:0], bit_in};
      if (par_en)
        par_q <= bit_in;
    end
  end

  assign last_bit = (cnt_q == CNT_W'(DATA_W - 1));
  assign par_good = rxf_pkg::parity_ok(^data_q, par_q);
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  input  logic in_vld,
  input  logic last_bit,
  input  logic par_good,
  input  logic fifo_full,
  input  logic err_clr,
  output logic cnt_clr,
  output logic shift_en,
  output logic par_en,
  output logic word_stb,
  output logic fifo_wr,
  output logic frame_done,
  output logic busy,
  output logic err_flag
);
  import rxf_pkg::*;

  rx_state_e st_q, st_d;
  logic frame_bad_q;
  logic stop_take, good_word, word_err, frame_end;

  // named events for assertions
  assign stop_take = (st_q == ST_STOP) && in_vld;
  assign good_word = word_ok(par_good, in_bit);
  assign word_err  = stop_take && !good_word;
  assign frame_end = (st_q == ST_CONT) && in_vld && (in_bit == STOP_LVL);

  assign shift_en = (st_q == ST_DATA) && in_vld;
  assign par_en   = (st_q == ST_PAR) && in_vld;
  assign cnt_clr  = in_vld && (in_bit == START_LVL) &&
                    ((st_q == ST_IDLE) || (st_q == ST_CONT));
  assign busy     = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    if (in_vld) begin
      unique case (st_q)
        ST_IDLE: if (in_bit == START_LVL) st_d = ST_DATA;
        ST_DATA: if (last_bit) st_d = ST_PAR;
        ST_PAR:  st_d = ST_STOP;
        ST_STOP: st_d = ST_CONT;
        ST_CONT: st_d = (in_bit == START_LVL) ? ST_DATA : ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      frame_bad_q <= 1'b0;
      word_stb    <= 1'b0;
      fifo_wr     <= 1'b0;
      frame_done  <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      st_q       <= st_d;
      word_stb   <= stop_take && good_word && !frame_bad_q;
      fifo_wr    <= stop_take && good_word && !frame_bad_q && !fifo_full;
      frame_done <= frame_end;
      if ((st_q == ST_IDLE) && cnt_clr)
        frame_bad_q <= 1'b0;
      else if (word_err)
        frame_bad_q <= 1'b1;
      if (word_err)
        err_flag <= 1'b1;
      else if (err_clr)
        err_flag <= 1'b0;
    end
  end

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_vld && in_bit));
  assert_no_wr_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !$past(fifo_full));
  assert_clean_frame_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> !$past(frame_bad_q));
  assert_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(st_q == ST_STOP && in_vld));
  assert_wr_implies_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> word_stb);
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_bit,
  input  logic              in_vld,
  input  logic              lb_en,
  input  logic              lb_bit,
  input  logic              lb_vld,
  input  logic              fifo_full,
  input  logic              err_clr,
  output logic [DATA_W-1:0] word_data,
  output logic              word_stb,
  output logic              fifo_wr,
  output logic              busy,
  output logic              frame_done,
  output logic              err_flag
);
  logic sel_bit, sel_vld;
  logic cnt_clr, shift_en, par_en, last_bit, par_good;

  rxf_src_mux u_mux (
    .lb_en(lb_en), .line_bit(in_bit), .line_vld(in_vld),
    .lb_bit(lb_bit), .lb_vld(lb_vld),
    .sel_bit(sel_bit), .sel_vld(sel_vld)
  );

  rxf_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .shift_en(shift_en),
    .par_en(par_en), .bit_in(sel_bit), .data_q(word_data),
    .last_bit(last_bit), .par_good(par_good)
  );

  rxf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_bit(sel_bit), .in_vld(sel_vld),
    .last_bit(last_bit), .par_good(par_good), .fifo_full(fifo_full),
    .err_clr(err_clr), .cnt_clr(cnt_clr), .shift_en(shift_en),
    .par_en(par_en), .word_stb(word_stb), .fifo_wr(fifo_wr),
    .frame_done(frame_done), .busy(busy), .err_flag(err_flag)
  );

  assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> $stable(word_data));
endmodule

// File: tb/frame_rx_tb.sv
module frame_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_bit = 1'b0, in_vld = 1'b0, lb_en = 1'b0, lb_bit = 1'b0, lb_vld = 1'b0;
  logic fifo_full = 1'b0, err_clr = 1'b0;
  logic [15:0] word_data;
  logic word_stb, fifo_wr, busy, frame_done, err_flag;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, stb_cnt = 0, done_cnt = 0;
  logic [15:0] wr_data = '0, stb_data = '0;

  always #2 clk = ~clk;

  frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_vld(in_vld),
    .lb_en(lb_en), .lb_bit(lb_bit), .lb_vld(lb_vld),
    .fifo_full(fifo_full), .err_clr(err_clr), .word_data(word_data),
    .word_stb(word_stb), .fifo_wr(fifo_wr), .busy(busy),
    .frame_done(frame_done), .err_flag(err_flag)
  );

  always @(negedge clk) begin
    if (fifo_wr) begin wr_cnt++; wr_data = word_data; end
    if (word_stb) begin stb_cnt++; stb_data = word_data; end
    if (frame_done) done_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bit: valid for one cycle, then a gap cycle; returns at negedge+1
  task automatic send_bit(input logic b, input logic use_lb, input logic noise);
    @(negedge clk);
    if (use_lb) begin lb_bit = b; lb_vld = 1'b1; end
    else begin in_bit = b; in_vld = 1'b1; end
    if (noise) begin in_bit = ~b; in_vld = 1'b1; end
    @(negedge clk);
    in_vld = 1'b0; lb_vld = 1'b0;
    #1;
  endtask

  task automatic send_word(input logic [15:0] d, input logic bad_par,
                           input logic bad_stop, input logic use_lb, input logic noise);
    send_bit(1'b1, use_lb, noise);
    for (int i = 15; i >= 0; i--) send_bit(d[i], use_lb, noise);
    send_bit((^d) ^ bad_par, use_lb, noise);
    send_bit(bad_stop, use_lb, noise);
  endtask

  // {data, bad parity, bad stop, last word of frame, expect write}
  localparam logic [19:0] VEC [9] = '{
    {16'h1234, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'hBEEF, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'h00FF, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h5555, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'hA5A5, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'h0F0F, 1'b0, 1'b1, 1'b0, 1'b0},
    {16'h7777, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1},
    {16'h8001, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w0, s0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 wr", wr_cnt, 0);
    check("R1 done", done_cnt, 0);
    check("R1 err", err_flag, 0);

    // vector table: R2 R3 R4 R5 R6 R8
    foreach (VEC[k]) begin
      w0 = wr_cnt; s0 = stb_cnt; d0 = done_cnt;
      send_word(VEC[k][19:4], VEC[k][3], VEC[k][2], 1'b0, 1'b0);
      check("R2/R5 write count", wr_cnt - w0, int'(VEC[k][0]));
      check("R8 stb count", stb_cnt - s0, int'(VEC[k][0]));
      if (VEC[k][0]) check("R2 data", wr_data, VEC[k][19:4]);
      if (VEC[k][3] || VEC[k][2]) check("R3/R4 err flag", err_flag, 1);
      send_bit(1'b1 & ~VEC[k][1], 1'b0, 1'b0);
      if (!VEC[k][0] == 1'b0) check("R8 data held", word_data, VEC[k][19:4]);
      if (VEC[k][1]) begin
        check("R6 done pulse", done_cnt - d0, 1);
        check("R7 busy end", busy, 0);
      end else begin
        check("R6 continue", done_cnt - d0, 0);
        check("R7 busy in frame", busy, 1);
        // the extra start bit was consumed; finish that word via the rest
        for (int i = 15; i >= 0; i--) begin end
      end
      if (!VEC[k][1]) begin
        // the continue bit above already acted as this next word's start
        // so the next vector is sent without its own start bit
        w0 = wr_cnt; s0 = stb_cnt; d0 = done_cnt;
      end
      if (!VEC[k][1] && k < 8) begin
        for (int i = 15; i >= 0; i--) send_bit(VEC[k+1][4+i], 1'b0, 1'b0);
        send_bit((^VEC[k+1][19:4]) ^ VEC[k+1][3], 1'b0, 1'b0);
        send_bit(VEC[k+1][2], 1'b0, 1'b0);
        check("R5 mid write count", wr_cnt - w0, int'(VEC[k+1][0]));
        if (VEC[k+1][0]) check("R2 mid data", wr_data, VEC[k+1][19:4]);
      end
    end

    // R11 sticky error then clear
    check("R11 sticky", err_flag, 1);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; #1;
    check("R11 cleared", err_flag, 0);

    // R7 busy after start
    send_bit(1'b1, 1'b0, 1'b0);
    check("R7 busy rise", busy, 1);
    for (int i = 15; i >= 0; i--) send_bit(i[0], 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    d0 = done_cnt;
    send_bit(1'b0, 1'b0, 1'b0);
    check("R6 done", done_cnt - d0, 1);

    // R9 FIFO full
    fifo_full = 1'b1;
    w0 = wr_cnt; s0 = stb_cnt; d0 = done_cnt;
    send_word(16'hC3C3, 1'b0, 1'b0, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    fifo_full = 1'b0;
    check("R9 no write", wr_cnt - w0, 0);
    check("R9 stb", stb_cnt - s0, 1);
    check("R9 stb data", stb_data, 16'hC3C3);
    check("R9 done", done_cnt - d0, 1);

    // R10 loopback with opposite line noise
    lb_en = 1'b1;
    w0 = wr_cnt; d0 = done_cnt;
    send_word(16'h6B2D, 1'b0, 1'b0, 1'b1, 1'b1);
    send_bit(1'b0, 1'b1, 1'b1);
    check("R10 lb write", wr_cnt - w0, 1);
    check("R10 lb data", wr_data, 16'h6B2D);
    check("R10 lb done", done_cnt - d0, 1);
    check("R10 lb no err", err_flag, 0);
    // R10 line ignored in loopback
    w0 = wr_cnt;
    send_word(16'h1111, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 line ignored busy", busy, 0);
    check("R10 line ignored wr", wr_cnt - w0, 0);
    lb_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule